// File: doc/BRIEF.md
# Disk Bus Activity Hold Gate

This block watches the serial lines of a disk bus and the two parallel handshake strobes. It raises a single access flag whenever it sees traffic. The flag then decides whether a drive's parallel port is wired through to the host's port. While the flag is low, whatever the drive does on its parallel lines cannot reach the host.

Each monitored line is sampled once per clock. A line whose value differs from the previous sample is an activity event. Both serial clock lines always qualify. The two strobes qualify only while the parallel option is enabled. The attention and data lines of both sides qualify only in the wide detection mode.

An activity event opens a hold window of `HOLD_CYCLES` clock cycles, and every later event restarts the window. `HOLD_CYCLES` defaults to half a second at 50 MHz. A force input pins the flag high.

The control is a three-state machine:
- IDLE: flag low. It goes to HOLD on an activity event and to FORCED when the force input is high.
- HOLD: flag high while a down-counter runs. An event reloads the counter. When the counter reaches zero with no event, the machine returns to IDLE. It goes to FORCED when the force input is high.
- FORCED: flag high. Activity is ignored. When the force input falls, the machine goes to HOLD with a fresh window.

Top module: `busact_gate`

## Requirements
- R1: A change on the host serial clock line between two consecutive samples sets the access flag to 1 at the following clock edge.
- R2: A change on the drive serial clock line sets the access flag to 1 at the following clock edge.
- R3: Changes on the incoming or outgoing strobe count as activity only while the parallel enable is 1; with the enable at 0 they leave the flag at 0.
- R4: With the wide mode input at 0, changes on host attention, host data, drive attention and drive data leave the flag at 0.
- R5: With the wide mode input at 1, a change on any of those four lines sets the flag like a clock change.
- R6: After the last activity event the flag stays 1 for exactly HOLD_CYCLES clock cycles and then returns to 0.
- R7: An activity event during a hold window restarts the window, so that the flag stays 1 for HOLD_CYCLES cycles counted from the newest event.
- R8: During synchronous reset (rst_n low) the flag is 0 and the stored line samples load from the current inputs, so that line levels different from those before reset raise no activity on the first cycle after reset.
- R9: While force_on_i is 1 the flag is 1 regardless of activity. When force_on_i falls, a fresh hold window of HOLD_CYCLES cycles starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_clk_i | input | 1 | Host-side serial clock line |
| drive_clk_i | input | 1 | Drive-side serial clock line |
| host_atn_i | input | 1 | Host-side attention line |
| host_data_i | input | 1 | Host-side serial data line |
| drive_atn_i | input | 1 | Drive-side attention line |
| drive_data_i | input | 1 | Drive-side serial data line |
| strb_in_i | input | 1 | Strobe from drive to host |
| strb_out_i | input | 1 | Strobe from host to drive |
| par_en_i | input | 1 | Parallel option enable; qualifies the strobes |
| wide_mode_i | input | 1 | Also watch attention and data lines |
| force_on_i | input | 1 | Hold the flag at 1 |
| access_o | output | 1 | Access flag, gates the parallel port |

## Verification
A wrong stored line sample shows up as a flag pulse, or a missing pulse, one cycle after the affected sample. A corrupted hold count moves the falling edge of the flag away from exactly HOLD_CYCLES cycles after the last event. Both faults therefore appear at the port within one hold window. For this reason every scenario measures the flag on every cycle of a full window plus one cycle beyond it, and does not look only at the final level.

// File: rtl/busact_pkg.sv
package busact_pkg;

    // positions of the monitored lines in the sampled vector
    localparam int LINE_HOST_CLK   = 0;
    localparam int LINE_DRIVE_CLK  = 1;
    localparam int LINE_STRB_IN    = 2;
    localparam int LINE_STRB_OUT   = 3;
    localparam int LINE_HOST_ATN   = 4;
    localparam int LINE_HOST_DATA  = 5;
    localparam int LINE_DRIVE_ATN  = 6;
    localparam int LINE_DRIVE_DATA = 7;
    localparam int NUM_LINES       = 8;

    typedef enum logic [1:0] {
        GATE_IDLE   = 2'd0,
        GATE_HOLD   = 2'd1,
        GATE_FORCED = 2'd2
    } gate_state_e;

endpackage

// File: rtl/line_change_det.sv
module line_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] changed_o
);
    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // during reset the sample follows the input, so nothing looks changed afterwards
        always_ff @(posedge clk) begin
            prev_q[b] <= lines_i[b];
        end
        always_comb begin
            changed_o[b] = rst_n & (lines_i[b] ^ prev_q[b]);
        end
    end
endmodule

// File: rtl/act_select.sv
module act_select
    import busact_pkg::*;
(
    input  logic [NUM_LINES-1:0] changed_i,
    input  logic                 par_en_i,
    input  logic                 wide_mode_i,
    output logic                 act_o
);
    logic clk_act;
    logic strb_act;
    logic wide_act;

    always_comb begin
        clk_act  = changed_i[LINE_HOST_CLK] | changed_i[LINE_DRIVE_CLK];
        strb_act = par_en_i & (changed_i[LINE_STRB_IN] | changed_i[LINE_STRB_OUT]);
        wide_act = wide_mode_i & (changed_i[LINE_HOST_ATN] | changed_i[LINE_HOST_DATA]
                                | changed_i[LINE_DRIVE_ATN] | changed_i[LINE_DRIVE_DATA]);
        act_o    = clk_act | strb_act | wide_act;
    end
endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import busact_pkg::*;
#(
    parameter int HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic force_i,
    output logic access_o
);
    localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    gate_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GATE_IDLE: begin
                if (force_i) begin
                    state_d = GATE_FORCED;
                end else if (act_i) begin
                    state_d = GATE_HOLD;
                    cnt_d   = RELOAD;
                end
            end
            GATE_HOLD: begin
                if (force_i) begin
                    state_d = GATE_FORCED;
                end else if (act_i) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = GATE_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            GATE_FORCED: begin
                if (!force_i) begin
                    state_d = GATE_HOLD;
                    cnt_d   = RELOAD;
                end
            end
            default: begin
                state_d = GATE_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        access_o = (state_q != GATE_IDLE);
    end

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);

    assert_no_early_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_HOLD && cnt_q != '0) |=> state_q != GATE_IDLE);

    assert_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_HOLD && cnt_q == '0 && !act_i && !force_i) |=> state_q == GATE_IDLE);

    assert_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && !force_i) |=> (state_q == GATE_HOLD && cnt_q == RELOAD));
endmodule

// File: rtl/busact_gate.sv
module busact_gate
    import busact_pkg::*;
#(
    parameter int HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clk_i,
    input  logic drive_clk_i,
    input  logic host_atn_i,
    input  logic host_data_i,
    input  logic drive_atn_i,
    input  logic drive_data_i,
    input  logic strb_in_i,
    input  logic strb_out_i,
    input  logic par_en_i,
    input  logic wide_mode_i,
    input  logic force_on_i,
    output logic access_o
);
    logic [NUM_LINES-1:0] lines;
    logic [NUM_LINES-1:0] changed;
    logic                 act;

    always_comb begin
        lines                  = '0;
        lines[LINE_HOST_CLK]   = host_clk_i;
        lines[LINE_DRIVE_CLK]  = drive_clk_i;
        lines[LINE_STRB_IN]    = strb_in_i;
        lines[LINE_STRB_OUT]   = strb_out_i;
        lines[LINE_HOST_ATN]   = host_atn_i;
        lines[LINE_HOST_DATA]  = host_data_i;
        lines[LINE_DRIVE_ATN]  = drive_atn_i;
        lines[LINE_DRIVE_DATA] = drive_data_i;
    end

    line_change_det #(.W(NUM_LINES)) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_i   (lines),
        .changed_o (changed)
    );

    act_select sel_i (
        .changed_i   (changed),
        .par_en_i    (par_en_i),
        .wide_mode_i (wide_mode_i),
        .act_o       (act)
    );

    hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .force_i  (force_on_i),
        .access_o (access_o)
    );

    assert_host_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clk_i != $past(host_clk_i)) |=> access_o);

    assert_drive_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_clk_i != $past(drive_clk_i)) |=> access_o);

    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_on_i |=> access_o);

    // R3/R4: a flag at rest stays at rest when no qualifying line moves
    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_o && !force_on_i && $stable(host_clk_i) && $stable(drive_clk_i)
         && (!par_en_i || ($stable(strb_in_i) && $stable(strb_out_i)))
         && (!wide_mode_i || ($stable(host_atn_i) && $stable(host_data_i)
                              && $stable(drive_atn_i) && $stable(drive_data_i))))
        |=> !access_o);
endmodule

// File: tb/busact_gate_tb_top.sv
module busact_gate_tb_top;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_clk = 1'b1, drive_clk = 1'b1, host_atn = 1'b1, host_data = 1'b1;
    logic drive_atn = 1'b1, drive_data = 1'b1, strb_in = 1'b1, strb_out = 1'b1;
    logic par_en = 1'b0, wide_mode = 1'b0, force_on = 1'b0;
    logic access;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    busact_gate #(.HOLD_CYCLES(H)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_clk_i(host_clk), .drive_clk_i(drive_clk),
        .host_atn_i(host_atn), .host_data_i(host_data),
        .drive_atn_i(drive_atn), .drive_data_i(drive_data),
        .strb_in_i(strb_in), .strb_out_i(strb_out),
        .par_en_i(par_en), .wide_mode_i(wide_mode), .force_on_i(force_on),
        .access_o(access)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (access !== exp) begin
            fails++;
            $display("FAIL %s: access_o=%b expected %b at %0t", req, access, exp, $time);
        end
    endtask

    // flag high for exactly H edges after the stimulus, low one edge later
    task automatic window(input string req);
        for (int k = 1; k <= H + 1; k++) begin
            tick();
            chk(k <= H, req);
        end
    endtask

    task automatic quiet(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(1'b0, req);
        end
    endtask

    task automatic t_reset_R8();
        host_clk = 1'b0; drive_clk = 1'b0; strb_in = 1'b0; par_en = 1'b1;
        tick();
        chk(1'b0, "R8 reset");
        rst_n = 1'b1;
        quiet(3, "R8 first cycles");
        par_en = 1'b0;
    endtask

    task automatic t_host_clk_R1();
        host_clk = ~host_clk;
        window("R1/R6 host clk");
    endtask

    task automatic t_drive_clk_R2();
        drive_clk = ~drive_clk;
        window("R2/R6 drive clk");
    endtask

    task automatic t_strobe_R3();
        par_en = 1'b0;
        strb_in = ~strb_in;
        quiet(2, "R3 strb_in gated");
        strb_out = ~strb_out;
        quiet(2, "R3 strb_out gated");
        par_en = 1'b1;
        quiet(1, "R3 enable alone");
        strb_in = ~strb_in;
        window("R3 strb_in enabled");
        strb_out = ~strb_out;
        window("R3 strb_out enabled");
        par_en = 1'b0;
    endtask

    task automatic t_narrow_R4();
        wide_mode = 1'b0;
        host_atn = ~host_atn;
        quiet(1, "R4 host atn");
        host_data = ~host_data;
        quiet(1, "R4 host data");
        drive_atn = ~drive_atn;
        quiet(1, "R4 drive atn");
        drive_data = ~drive_data;
        quiet(2, "R4 drive data");
    endtask

    task automatic t_wide_R5();
        wide_mode = 1'b1;
        quiet(1, "R5 mode alone");
        drive_data = ~drive_data;
        window("R5 drive data");
        host_atn = ~host_atn;
        window("R5 host atn");
        wide_mode = 1'b0;
    endtask

    task automatic t_retrigger_R7();
        host_clk = ~host_clk;
        for (int k = 0; k < H - 3; k++) begin
            tick();
            chk(1'b1, "R7 first window");
        end
        drive_clk = ~drive_clk;
        window("R7 restarted window");
    endtask

    task automatic t_force_R9();
        force_on = 1'b1;
        for (int k = 0; k < 2 * H; k++) begin
            tick();
            chk(1'b1, "R9 forced");
        end
        force_on = 1'b0;
        window("R9 release window");
    endtask

    initial begin
        t_reset_R8();
        t_host_clk_R1();
        t_drive_clk_R2();
        t_strobe_R3();
        t_narrow_R4();
        t_wide_R5();
        t_retrigger_R7();
        t_force_R9();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule